// File: doc/BRIEF.md
# Sticky Interrupt Status Register Set

This block gathers level conditions from the FIFOs and sequencer of a serial flash controller, plus one access-error condition, into a 32-bit status register whose bits stay set once their condition has been seen. A second register selects the status bits that may raise the single active-high, level-sensitive interrupt line. Software clears a status bit by writing a one to the matching bit of a third register.

If a condition is still true when its bit is cleared, the bit sets again on the same clock edge. Driver code can use this to sample a live FIFO condition: it clears the bit, reads the status register, and learns whether the condition holds now. The access-error bit is raised inside the block. It sets when a push into the transmit FIFO is attempted while the FIFO is full, or when a pop from the receive FIFO is attempted while that FIFO is empty.

The register port is a single-cycle request interface. A write takes effect at the clock edge where it is presented. A read returns its data one cycle later, qualified by `rvalid_o`.

Top module: `irq_sticky_top`

## Requirements
- R1: The registers sit at byte offsets 0x30 (status, read-only), 0x34 (enable, read/write) and 0x38 (clear, write-only). A read of the clear offset, or of any other offset, returns 0. Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the read request.
- R2: The status bits are assigned as follows: transmit trigger bit 0, transmit empty bit 1, transmit half full bit 2, transmit full bit 3, receive trigger bit 5, receive word available bit 6, receive half full bit 7, receive full bit 8, all done bit 9, receive byte available bit 11, access error bit 12.
- R3: A status bit sets at the first clock edge where its condition input is high. It stays set after the condition drops, until software clears it.
- R4: Writing the clear register clears exactly those status bits whose written bit is one. Bits written as zero keep their value, so a write of all zeros changes nothing.
- R5: If a bit's condition is high at the edge where that bit is cleared, the set wins and the bit reads back as set. This holds both for a held condition and for a one-cycle pulse that coincides with the clear.
- R6: `irq_o` is high exactly when some status bit is set and its enable bit is also set. A set status bit whose enable is zero does not raise `irq_o`.
- R7: The access-error bit (12) sets when `tx_push_i` is high while `tx_full_i` is high, or when `rx_pop_i` is high while `rx_empty_i` is high. A push while the transmit FIFO is not full does not set it.
- R8: After reset, the status and enable registers are zero and `irq_o` is low.
- R9: Bits 4, 10 and 13 to 31 of the status and enable registers always read zero. Writes to those enable bits are dropped, so writing all ones to enable reads back 0x00001BEF.
- R10: Writes to the status offset have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| tx_trig_i | input | 1 | Transmit level at trigger threshold |
| tx_empty_i | input | 1 | Transmit FIFO fully drained |
| tx_half_i | input | 1 | Transmit FIFO half full |
| tx_full_i | input | 1 | Transmit FIFO full |
| rx_trig_i | input | 1 | Receive level at trigger threshold |
| rx_word_i | input | 1 | At least one 32-bit receive word available |
| rx_half_i | input | 1 | Receive FIFO half full |
| rx_full_i | input | 1 | Receive FIFO full |
| done_i | input | 1 | Transaction fully done |
| rx_byte_i | input | 1 | At least one receive byte available |
| tx_push_i | input | 1 | Push attempt on the transmit FIFO |
| rx_pop_i | input | 1 | Pop attempt on the receive FIFO |
| rx_empty_i | input | 1 | Receive FIFO empty |
| irq_o | output | 1 | Level-high interrupt |

## Verification
A condition that sets a status bit and a software write that clears the same bit can land on the same clock edge. The bench provokes this in two ways. In one, a condition stays high across a clear write. In the other, a condition is pulsed for exactly the cycle of the clear write, on a bit that was already set. In both cases a later read must still show the bit set. Each such case is paired with a plain clear, with the condition low, that must read back zero, so a design where the clear wins is caught.

// File: rtl/irq_sticky_pkg.sv
package irq_sticky_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFS_STATUS = 8'h30;
  localparam logic [7:0] OFS_ENABLE = 8'h34;
  localparam logic [7:0] OFS_CLEAR  = 8'h38;

  localparam int B_TX_TRIG  = 0;
  localparam int B_TX_EMPTY = 1;
  localparam int B_TX_HALF  = 2;
  localparam int B_TX_FULL  = 3;
  localparam int B_RX_TRIG  = 5;
  localparam int B_RX_WORD  = 6;
  localparam int B_RX_HALF  = 7;
  localparam int B_RX_FULL  = 8;
  localparam int B_DONE     = 9;
  localparam int B_RX_BYTE  = 11;
  localparam int B_ACC_ERR  = 12;

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << B_TX_TRIG) | (REG_W'(1) << B_TX_EMPTY) |
      (REG_W'(1) << B_TX_HALF) | (REG_W'(1) << B_TX_FULL)  |
      (REG_W'(1) << B_RX_TRIG) | (REG_W'(1) << B_RX_WORD)  |
      (REG_W'(1) << B_RX_HALF) | (REG_W'(1) << B_RX_FULL)  |
      (REG_W'(1) << B_DONE)    | (REG_W'(1) << B_RX_BYTE)  |
      (REG_W'(1) << B_ACC_ERR);

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_CLEAR
  } reg_sel_e;
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_sticky_pkg::*;
(
  input  logic             tx_trig_i,
  input  logic             tx_empty_i,
  input  logic             tx_half_i,
  input  logic             tx_full_i,
  input  logic             rx_trig_i,
  input  logic             rx_word_i,
  input  logic             rx_half_i,
  input  logic             rx_full_i,
  input  logic             done_i,
  input  logic             rx_byte_i,
  input  logic             tx_push_i,
  input  logic             rx_pop_i,
  input  logic             rx_empty_i,
  output logic [REG_W-1:0] evt_o
);
  logic acc_err;

  // push into full tx, or pop from empty rx
  assign acc_err = (tx_push_i & tx_full_i) | (rx_pop_i & rx_empty_i);

  always_comb begin
    evt_o             = '0;
    evt_o[B_TX_TRIG]  = tx_trig_i;
    evt_o[B_TX_EMPTY] = tx_empty_i;
    evt_o[B_TX_HALF]  = tx_half_i;
    evt_o[B_TX_FULL]  = tx_full_i;
    evt_o[B_RX_TRIG]  = rx_trig_i;
    evt_o[B_RX_WORD]  = rx_word_i;
    evt_o[B_RX_HALF]  = rx_half_i;
    evt_o[B_RX_FULL]  = rx_full_i;
    evt_o[B_DONE]     = done_i;
    evt_o[B_RX_BYTE]  = rx_byte_i;
    evt_o[B_ACC_ERR]  = acc_err;
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[i]) bit_q <= 1'b1;  // set beats clear
      else if (clr_i[i]) bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_sticky_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  status_i,
  output logic [REG_W-1:0]  enable_o,
  output logic [REG_W-1:0]  clr_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rvalid_o
);
  reg_sel_e         sel;
  logic [REG_W-1:0] enable_q, rdata_q, rdata_d;
  logic             rvalid_q;

  always_comb begin
    if (addr_i == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
    else if (addr_i == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
    else if (addr_i == ADDR_W'(OFS_CLEAR))  sel = SEL_CLEAR;
    else                                    sel = SEL_NONE;
  end

  assign clr_o = (req_i && we_i && sel == SEL_CLEAR) ? wdata_i : '0;

  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_d = status_i;
      SEL_ENABLE: rdata_d = enable_q;
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i & ~we_i;
      if (req_i && !we_i) rdata_q <= rdata_d;
      if (req_i && we_i && sel == SEL_ENABLE) enable_q <= wdata_i & IMPL_MASK;
    end
  end

  assign enable_o = enable_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/irq_sticky_top.sv
module irq_sticky_top
  import irq_sticky_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic              tx_trig_i,
  input  logic              tx_empty_i,
  input  logic              tx_half_i,
  input  logic              tx_full_i,
  input  logic              rx_trig_i,
  input  logic              rx_word_i,
  input  logic              rx_half_i,
  input  logic              rx_full_i,
  input  logic              done_i,
  input  logic              rx_byte_i,
  input  logic              tx_push_i,
  input  logic              rx_pop_i,
  input  logic              rx_empty_i,
  output logic              irq_o
);
  logic [REG_W-1:0] evt_w, clr_w, status_w, enable_w;

  irq_src_map u_map (
    .tx_trig_i (tx_trig_i),
    .tx_empty_i(tx_empty_i),
    .tx_half_i (tx_half_i),
    .tx_full_i (tx_full_i),
    .rx_trig_i (rx_trig_i),
    .rx_word_i (rx_word_i),
    .rx_half_i (rx_half_i),
    .rx_full_i (rx_full_i),
    .done_i    (done_i),
    .rx_byte_i (rx_byte_i),
    .tx_push_i (tx_push_i),
    .rx_pop_i  (rx_pop_i),
    .rx_empty_i(rx_empty_i),
    .evt_o     (evt_w)
  );

  irq_status_bank #(.W(REG_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_w),
    .clr_i   (clr_w),
    .status_o(status_w)
  );

  irq_reg_if #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .status_i(status_w),
    .enable_o(enable_w),
    .clr_o   (clr_w),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  assign irq_o = |(status_w & enable_w);
endmodule

// File: rtl/irq_sticky_chk.sv
module irq_sticky_chk
  import irq_sticky_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] evt_w,
  input logic [REG_W-1:0] clr_w,
  input logic [REG_W-1:0] status_w,
  input logic [REG_W-1:0] enable_w,
  input logic             tx_push_i,
  input logic             tx_full_i,
  input logic             rx_pop_i,
  input logic             rx_empty_i,
  input logic             irq_o
);
  AST_EVT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_w != '0) |=> ((status_w & $past(evt_w)) == $past(evt_w))); // R5

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w == '0) |=> ((status_w & $past(status_w)) == $past(status_w))); // R3

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_w & ~evt_w) != '0) |=> ((status_w & $past(clr_w & ~evt_w)) == '0)); // R4

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_w == '0) |-> !irq_o); // R6

  AST_ACC_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tx_push_i && tx_full_i) || (rx_pop_i && rx_empty_i)) |=> status_w[B_ACC_ERR]); // R7

  AST_UNIMPL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w | enable_w) & ~IMPL_MASK) == '0); // R9
endmodule

bind irq_sticky_top irq_sticky_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_w     (evt_w),
  .clr_w     (clr_w),
  .status_w  (status_w),
  .enable_w  (enable_w),
  .tx_push_i (tx_push_i),
  .tx_full_i (tx_full_i),
  .rx_pop_i  (rx_pop_i),
  .rx_empty_i(rx_empty_i),
  .irq_o     (irq_o)
);

// File: tb/irq_sticky_top_tb.sv
module irq_sticky_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h30, A_EN = 8'h34, A_CLR = 8'h38;
  localparam logic [31:0] MASK = 32'h0000_1BEF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic rvalid, irq;
  logic [9:0] src = '0;
  logic tx_push = 0, rx_pop = 0, rx_empty = 0;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sticky_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .tx_trig_i(src[0]), .tx_empty_i(src[1]), .tx_half_i(src[2]),
    .tx_full_i(src[3]), .rx_trig_i(src[4]), .rx_word_i(src[5]),
    .rx_half_i(src[6]), .rx_full_i(src[7]), .done_i(src[8]),
    .rx_byte_i(src[9]), .tx_push_i(tx_push), .rx_pop_i(rx_pop),
    .rx_empty_i(rx_empty), .irq_o(irq)
  );

  function automatic int pos_of(int idx);
    case (idx)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 5;  5: return 6;  6: return 7;  7: return 8;
      8: return 9;  default: return 11;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); req = 0;
  endtask

  // monitor: pop and compare as read data appears
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected rvalid act=%08h exp=none", rdata);
      end else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1; idle(1);
        chk("R8 irq after reset", 32'(irq), 0);
        rd(A_STAT, 0, "R8 status after reset");
        rd(A_EN, 0, "R8 enable after reset");
        rd(A_CLR, 0, "R1 clear reads zero");
        rd(8'h3C, 0, "R1 other offset reads zero");

        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, MASK, "R9 enable readback mask");

        // each source: pulse, sticky, irq, clear
        for (int i = 0; i < 10; i++) begin
          @(negedge clk); src[i] = 1;
          @(negedge clk); src[i] = 0;
          idle(1);
          rd(A_STAT, 32'(1) << pos_of(i), $sformatf("R2 R3 src %0d latched", i));
          chk("R6 irq with enabled bit", 32'(irq), 1);
          wr(A_CLR, 32'(1) << pos_of(i));
          rd(A_STAT, 0, "R4 cleared");
          chk("R6 irq low after clear", 32'(irq), 0);
        end

        // status write ignored
        @(negedge clk); src[8] = 1; @(negedge clk); src[8] = 0;
        wr(A_STAT, 32'h0000_0000);
        rd(A_STAT, 32'h200, "R10 status write ignored");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h200, "R10 R9 ones write ignored");

        // zero clear has no effect; partial clear
        @(negedge clk); src[0] = 1; @(negedge clk); src[0] = 0;
        wr(A_CLR, 0);
        rd(A_STAT, 32'h201, "R4 zero clear no effect");
        wr(A_CLR, 32'h200);
        rd(A_STAT, 32'h001, "R4 partial clear");
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_STAT, 0, "R4 clear all");

        // held condition re-latches
        @(negedge clk); src[1] = 1;
        idle(1);
        wr(A_CLR, 32'h2);
        rd(A_STAT, 32'h2, "R5 held condition survives clear");
        src[1] = 0;
        wr(A_CLR, 32'h2);
        rd(A_STAT, 0, "R5 clear after drop");

        // pulse coinciding with clear
        @(negedge clk); src[7] = 1; @(negedge clk); src[7] = 0;
        @(negedge clk); req = 1; we = 1; addr = A_CLR; wdata = 32'h100; src[7] = 1;
        @(negedge clk); req = 0; we = 0; src[7] = 0;
        rd(A_STAT, 32'h100, "R5 set wins same cycle");
        wr(A_CLR, 32'h100);
        rd(A_STAT, 0, "R5 clear alone drops");

        // enable gating
        wr(A_EN, 32'h0000_0004);
        @(negedge clk); src[3] = 1; @(negedge clk); src[3] = 0;
        idle(1);
        chk("R6 disabled bit no irq", 32'(irq), 0);
        @(negedge clk); src[2] = 1; @(negedge clk); src[2] = 0;
        idle(1);
        chk("R6 enabled bit irq", 32'(irq), 1);
        wr(A_CLR, 32'hFFFF_FFFF);
        chk("R6 irq drops", 32'(irq), 0);

        // access error
        @(negedge clk); tx_push = 1; @(negedge clk); tx_push = 0;
        rd(A_STAT, 0, "R7 push not full no error");
        @(negedge clk); tx_push = 1; src[3] = 1;
        @(negedge clk); tx_push = 0; src[3] = 0;
        rd(A_STAT, 32'h1008, "R7 push while full");
        wr(A_CLR, 32'hFFFF_FFFF);
        @(negedge clk); rx_pop = 1; rx_empty = 1;
        @(negedge clk); rx_pop = 0; rx_empty = 0;
        rd(A_STAT, 32'h1000, "R7 pop while empty");
        wr(A_EN, 32'h1000);
        chk("R6 R7 error irq", 32'(irq), 1);

        idle(3);
        chk("R1 scoreboard drained", 32'(exp_q.size()), 0);
      end
      begin
        idle(20000);
        checks++; errors++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule